// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Guard with Scrub Writeback

This block protects 64-bit words on their way between a memory controller and its storage array. On the write side it turns a data word into a 72-bit codeword by adding seven Hamming check bits and one overall even-parity bit. The controller stores that codeword. On the read side the stored codeword comes back in. The block recomputes the syndrome and the overall parity, repairs any single flipped bit, and marks as uncorrectable any pattern it cannot repair, such as two flipped bits. The result is presented one clock later with a corrected flag and an uncorrectable flag.

When a read needs a repair and scrubbing is enabled, the block raises a writeback request. The request carries the read address and the repaired codeword, and it stays up until the storage side acknowledges it, so a weak cell is rewritten with clean contents. Two saturating counters, one for repaired reads and one for uncorrectable reads, give software a way to spot memory that is failing. A one-cycle clear pulse resets both counters.

Top module: `ecc_scrub_guard`

## Requirements
- R1: `wr_code_o` is the codeword for `wr_data_i`, with no clock delay. Bit index equals Hamming position. Data bits fill positions 1..71 that are not powers of two, in rising order, with data bit 0 at the lowest such position. The bit at position 2^k (k = 0..6) makes the XOR over all set positions having bit k of their index set equal zero. Bit 0 makes the XOR of all 72 bits zero.
- R2: `rd_valid_o` follows `rd_valid_i` one clock later. In a cycle where `rd_valid_o` is low, both flags are low.
- R3: A codeword with zero syndrome and even overall parity returns its data unchanged, with both flags low.
- R4: A single flipped bit at any position from 1 to 71 is repaired. The original data is returned with `rd_corrected_o` high.
- R5: A flip of bit 0 alone (zero syndrome, odd parity) returns the data unchanged with `rd_corrected_o` high.
- R6: The following reads raise `rd_uncorr_o` and leave `rd_corrected_o` low: a nonzero syndrome with even parity, or a syndrome above 71 with odd parity. In that case the raw data bits are returned unrepaired.
- R7: A repaired read while `scrub_en_i` is high raises `scrub_req_o` in the same cycle as the read result. The request carries the read address and the fully repaired codeword, and address, codeword and request are held until a cycle with `scrub_ack_i` high.
- R8: No scrub request is raised for clean or uncorrectable reads, or while `scrub_en_i` is low.
- R9: While a request is pending and not acknowledged, a new repaired read does not replace it. If the acknowledge falls in the same cycle as a new repaired read, the new request is loaded in its place.
- R10: `corr_count_o` counts repaired reads and `uncorr_count_o` counts uncorrectable reads. Each counter stops at its all-ones value.
- R11: A `cnt_clear_i` pulse zeroes both counters. A read event in the same cycle as the clear leaves its counter at 1.
- R12: After reset, all outputs except `wr_code_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 64 | Data word to encode |
| wr_code_o | output | 72 | Codeword to store |
| rd_valid_i | input | 1 | A stored codeword is presented |
| rd_addr_i | input | ADDR_W | Address of the presented codeword |
| rd_code_i | input | 72 | Codeword read from storage |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Read data, repaired where possible |
| rd_corrected_o | output | 1 | A single error was repaired |
| rd_uncorr_o | output | 1 | An uncorrectable error was found |
| scrub_en_i | input | 1 | Allow scrub writeback requests |
| scrub_req_o | output | 1 | Writeback request pending |
| scrub_ack_i | input | 1 | Storage accepts the writeback |
| scrub_addr_o | output | ADDR_W | Writeback address |
| scrub_code_o | output | 72 | Repaired codeword to write |
| cnt_clear_i | input | 1 | Clear both event counters |
| corr_count_o | output | CNT_W | Saturating count of repaired reads |
| uncorr_count_o | output | CNT_W | Saturating count of uncorrectable reads |

## Verification
The collision that matters is a writeback acknowledge that lands in the same cycle as a new repaired read. The slot must then retire the old request and capture the new address and codeword, rather than dropping one of them. The bench first leaves a request unacknowledged across an idle cycle and across another repaired read, and checks that the first address stays. It then drives the acknowledge and a third repaired read on the same edge, and expects the third address and its clean codeword to appear with the request still high. A separate step lines up a counter clear with an uncorrectable read and expects the count to be 1.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   // Smallest number of Hamming bits k such that 2^k covers data, check bits and the zero position.
   function automatic int hamming_bits(input int dw);
      int r;
      r = 0;
      for (int k = 31; k >= 1; k--)
         if ((64'd1 << k) >= 64'(dw + k + 1)) r = k;
      return r;
   endfunction

   typedef enum logic [1:0] {
      RD_CLEAN = 2'd0,
      RD_FIXED = 2'd1,
      RD_FATAL = 2'd2
   } rd_class_e;

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]                                    data_i,
   output logic [DATA_W+ecc_pkg::hamming_bits(DATA_W):0]        code_o
);
   localparam int HAM_W  = ecc_pkg::hamming_bits(DATA_W);
   localparam int CODE_W = DATA_W + HAM_W + 1;
   localparam int IDX_W  = $clog2(CODE_W);
   localparam int DIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   always_comb begin : enc_body
      logic [CODE_W-1:0] c;
      logic [HAM_W-1:0]  s;
      int                d;
      c = '0;
      s = '0;
      d = 0;
      for (int p = 1; p < CODE_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            c[IDX_W'(p)] = data_i[DIDX_W'(d)];
            if (data_i[DIDX_W'(d)]) s = s ^ HAM_W'(p);
            d = d + 1;
         end
      end
      for (int k = 0; k < HAM_W; k++)
         c[IDX_W'(1 << k)] = s[k];
      c[0] = ^c[CODE_W-1:1];
      code_o = c;
   end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W+ecc_pkg::hamming_bits(DATA_W):0] code_i,
   output logic [DATA_W+ecc_pkg::hamming_bits(DATA_W):0] fixed_o,
   output logic [DATA_W-1:0]                             data_o,
   output ecc_pkg::rd_class_e                            class_o
);
   import ecc_pkg::*;
   localparam int HAM_W  = hamming_bits(DATA_W);
   localparam int CODE_W = DATA_W + HAM_W + 1;
   localparam int IDX_W  = $clog2(CODE_W);
   localparam int DIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   logic [HAM_W-1:0] syn;
   logic             par_odd;

   always_comb begin : dec_body
      int d;
      syn = '0;
      for (int p = 1; p < CODE_W; p++)
         if (code_i[IDX_W'(p)]) syn = syn ^ HAM_W'(p);
      par_odd = ^code_i;
      fixed_o = code_i;
      if (par_odd && (int'(syn) < CODE_W)) begin
         // syndrome 0 with odd parity points at the parity bit itself
         fixed_o[IDX_W'(syn)] = ~code_i[IDX_W'(syn)];
         class_o = RD_FIXED;
      end else if (par_odd || (syn != '0)) begin
         class_o = RD_FATAL;
      end else begin
         class_o = RD_CLEAN;
      end
      data_o = '0;
      d = 0;
      for (int p = 1; p < CODE_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            data_o[DIDX_W'(d)] = fixed_o[IDX_W'(p)];
            d = d + 1;
         end
      end
   end
endmodule

// File: rtl/ecc_scrub_slot.sv
module ecc_scrub_slot #(
   parameter int ADDR_W = 16,
   parameter int CODE_W = 72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              ack_i,
   output logic              req_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CODE_W-1:0] code_o
);
   logic slot_free;
   assign slot_free = !req_o || ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_o  <= 1'b0;
         addr_o <= '0;
         code_o <= '0;
      end else if (load_i && slot_free) begin
         req_o  <= 1'b1;
         addr_o <= addr_i;
         code_o <= code_i;
      end else if (ack_i) begin
         req_o  <= 1'b0;
      end
   end
endmodule

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     count_o <= '0;
      else if (clr_i)                 count_o <= CNT_W'(inc_i);
      else if (inc_i && count_o != TOP) count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/ecc_scrub_guard.sv
module ecc_scrub_guard #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   localparam int CODE_W = DATA_W + ecc_pkg::hamming_bits(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [CODE_W-1:0] wr_code_o,
   input  logic              rd_valid_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [CODE_W-1:0] rd_code_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_corrected_o,
   output logic              rd_uncorr_o,
   input  logic              scrub_en_i,
   output logic              scrub_req_o,
   input  logic              scrub_ack_i,
   output logic [ADDR_W-1:0] scrub_addr_o,
   output logic [CODE_W-1:0] scrub_code_o,
   input  logic              cnt_clear_i,
   output logic [CNT_W-1:0]  corr_count_o,
   output logic [CNT_W-1:0]  uncorr_count_o
);
   import ecc_pkg::*;

   initial begin
      if (DATA_W < 4)  $fatal(1, "DATA_W must be at least 4");
      if (ADDR_W < 1)  $fatal(1, "ADDR_W must be at least 1");
      if (CNT_W < 1)   $fatal(1, "CNT_W must be at least 1");
   end

   ecc_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (wr_data_i),
      .code_o (wr_code_o)
   );

   logic [CODE_W-1:0] fixed_code;
   logic [DATA_W-1:0] dec_data;
   rd_class_e         dec_class;

   ecc_dec #(.DATA_W(DATA_W)) u_dec (
      .code_i  (rd_code_i),
      .fixed_o (fixed_code),
      .data_o  (dec_data),
      .class_o (dec_class)
   );

   logic fix_ev, fatal_ev;
   assign fix_ev   = rd_valid_i && (dec_class == RD_FIXED);
   assign fatal_ev = rd_valid_i && (dec_class == RD_FATAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o     <= 1'b0;
         rd_data_o      <= '0;
         rd_corrected_o <= 1'b0;
         rd_uncorr_o    <= 1'b0;
      end else begin
         rd_valid_o     <= rd_valid_i;
         rd_corrected_o <= fix_ev;
         rd_uncorr_o    <= fatal_ev;
         if (rd_valid_i) rd_data_o <= dec_data;
      end
   end

   ecc_scrub_slot #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (fix_ev && scrub_en_i),
      .addr_i (rd_addr_i),
      .code_i (fixed_code),
      .ack_i  (scrub_ack_i),
      .req_o  (scrub_req_o),
      .addr_o (scrub_addr_o),
      .code_o (scrub_code_o)
   );

   logic [1:0]       ev_vec;
   logic [CNT_W-1:0] cnt_arr [2];
   assign ev_vec = {fatal_ev, fix_ev};

   for (genvar g = 0; g < 2; g++) begin : g_cnt
      ecc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (cnt_clear_i),
         .inc_i   (ev_vec[g]),
         .count_o (cnt_arr[g])
      );
   end

   assign corr_count_o   = cnt_arr[0];
   assign uncorr_count_o = cnt_arr[1];
endmodule

// File: rtl/ecc_scrub_guard_chk.sv
module ecc_scrub_guard_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int CODE_W = 72
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_valid_i,
   input logic              rd_valid_o,
   input logic              rd_corrected_o,
   input logic              rd_uncorr_o,
   input logic              scrub_req_o,
   input logic              scrub_ack_i,
   input logic [ADDR_W-1:0] scrub_addr_o,
   input logic [CODE_W-1:0] scrub_code_o,
   input logic              cnt_clear_i,
   input logic [CNT_W-1:0]  corr_count_o,
   input logic [CNT_W-1:0]  uncorr_count_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_i |=> rd_valid_o);
   p_flags_need_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_corrected_o || rd_uncorr_o) |-> rd_valid_o);
   p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_corrected_o && rd_uncorr_o));
   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (scrub_req_o && !scrub_ack_i) |=>
         (scrub_req_o && $stable(scrub_addr_o) && $stable(scrub_code_o)));
   p_req_from_fix_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scrub_req_o) |-> rd_corrected_o);
   p_corr_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clear_i && corr_count_o == TOP) |=> corr_count_o == TOP);
   p_uncorr_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clear_i |=> uncorr_count_o >= $past(uncorr_count_o));
   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clear_i |=> (corr_count_o <= 1 && uncorr_count_o <= 1));
endmodule

bind ecc_scrub_guard ecc_scrub_guard_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rd_valid_i     (rd_valid_i),
   .rd_valid_o     (rd_valid_o),
   .rd_corrected_o (rd_corrected_o),
   .rd_uncorr_o    (rd_uncorr_o),
   .scrub_req_o    (scrub_req_o),
   .scrub_ack_i    (scrub_ack_i),
   .scrub_addr_o   (scrub_addr_o),
   .scrub_code_o   (scrub_code_o),
   .cnt_clear_i    (cnt_clear_i),
   .corr_count_o   (corr_count_o),
   .uncorr_count_o (uncorr_count_o)
);

// File: tb/sim_ecc_scrub_guard.sv
module sim_ecc_scrub_guard;
   localparam int AW = 8;
   localparam int CW = 3;
   localparam logic [6:0] NONE = 7'd127;

   typedef struct packed {
      logic [63:0] d;
      logic [6:0]  f1;
      logic [6:0]  f2;
      logic [6:0]  f3;
      logic [1:0]  cls;   // 0 clean, 1 repaired, 2 uncorrectable
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{64'h0000_0000_0000_0000, NONE,  NONE,  NONE, 2'd0},
      '{64'hDEAD_BEEF_0123_4567, NONE,  NONE,  NONE, 2'd0},
      '{64'hFFFF_FFFF_FFFF_FFFF, 7'd3,  NONE,  NONE, 2'd1},
      '{64'hA5A5_5A5A_A5A5_5A5A, 7'd71, NONE,  NONE, 2'd1},
      '{64'h1234_5678_9ABC_DEF0, 7'd0,  NONE,  NONE, 2'd1},
      '{64'h0F0F_0F0F_F0F0_F0F0, 7'd16, NONE,  NONE, 2'd1},
      '{64'hCAFE_F00D_1357_9BDF, 7'd5,  7'd40, NONE, 2'd2},
      '{64'h7777_3333_1111_EEEE, 7'd64, 7'd9,  7'd1, 2'd2},
      '{64'h8000_0000_0000_0001, 7'd0,  7'd1,  NONE, 2'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [63:0]   wr_data_i = '0;
   logic [71:0]   wr_code_o;
   logic          rd_valid_i = 1'b0;
   logic [AW-1:0] rd_addr_i = '0;
   logic [71:0]   rd_code_i = '0;
   logic          rd_valid_o;
   logic [63:0]   rd_data_o;
   logic          rd_corrected_o, rd_uncorr_o;
   logic          scrub_en_i = 1'b0;
   logic          scrub_req_o;
   logic          scrub_ack_i = 1'b0;
   logic [AW-1:0] scrub_addr_o;
   logic [71:0]   scrub_code_o;
   logic          cnt_clear_i = 1'b0;
   logic [CW-1:0] corr_count_o, uncorr_count_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int exp_corr = 0;
   int exp_unc  = 0;

   always #10 clk = ~clk;

   ecc_scrub_guard #(.DATA_W(64), .ADDR_W(AW), .CNT_W(CW)) u0 (.*);

   // Codeword model written from R1: check bit k is the parity of the covered positions.
   function automatic logic [71:0] model_enc(input logic [63:0] d);
      logic [71:0] c;
      int n;
      c = '0;
      n = 0;
      for (int p = 1; p < 72; p++)
         if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
            c[p] = d[n];
            n++;
         end
      for (int k = 0; k < 7; k++) begin
         logic b;
         b = 1'b0;
         for (int p = 1; p < 72; p++)
            if (((p >> k) & 1) == 1) b = b ^ c[p];
         c[1 << k] = b;
      end
      c[0] = ^c[71:1];
      return c;
   endfunction

   function automatic logic [63:0] model_raw(input logic [71:0] c);
      logic [63:0] d;
      int n;
      n = 0;
      d = '0;
      for (int p = 3; p < 72; p++)
         if ((p & (p - 1)) != 0) begin
            d[n] = c[p];
            n++;
         end
      return d;
   endfunction

   function automatic logic [71:0] flip(input logic [71:0] c, input logic [6:0] pos);
      logic [71:0] r;
      r = c;
      if (pos != NONE) r[pos] = ~r[pos];
      return r;
   endfunction

   task automatic expect_eq(input string tag, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after the result register loads.
   task automatic do_read(input logic [AW-1:0] a, input logic [71:0] c);
      rd_valid_i = 1'b1;
      rd_addr_i  = a;
      rd_code_i  = c;
      @(posedge clk);
      @(negedge clk);
      rd_valid_i = 1'b0;
   endtask

   function automatic int sat(input int v);
      return (v > 7) ? 7 : v;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [71:0] cw;
      logic [63:0] xd;
      repeat (3) @(negedge clk);
      // R12 reset state
      expect_eq("R12 rd_valid_o", 72'(rd_valid_o), 72'd0);
      expect_eq("R12 rd_data_o", 72'(rd_data_o), 72'd0);
      expect_eq("R12 flags", 72'({rd_corrected_o, rd_uncorr_o}), 72'd0);
      expect_eq("R12 scrub_req_o", 72'(scrub_req_o), 72'd0);
      expect_eq("R12 counters", 72'({corr_count_o, uncorr_count_o}), 72'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R1, R3, R4, R5, R6, R10
      for (int i = 0; i < 9; i++) begin
         wr_data_i = VEC[i].d;
         #1;
         expect_eq("R1 wr_code_o", wr_code_o, model_enc(VEC[i].d));
         cw = flip(flip(flip(model_enc(VEC[i].d), VEC[i].f1), VEC[i].f2), VEC[i].f3);
         do_read(AW'(i), cw);
         expect_eq("R2 rd_valid_o", 72'(rd_valid_o), 72'd1);
         if (VEC[i].cls == 2'd0) begin
            expect_eq("R3 clean data", 72'(rd_data_o), 72'(VEC[i].d));
            expect_eq("R3 clean flags", 72'({rd_corrected_o, rd_uncorr_o}), 72'd0);
         end else if (VEC[i].cls == 2'd1) begin
            exp_corr++;
            expect_eq(VEC[i].f1 == 7'd0 ? "R5 data" : "R4 data", 72'(rd_data_o), 72'(VEC[i].d));
            expect_eq(VEC[i].f1 == 7'd0 ? "R5 flags" : "R4 flags",
                      72'({rd_corrected_o, rd_uncorr_o}), 72'b10);
         end else begin
            exp_unc++;
            expect_eq("R6 raw data", 72'(rd_data_o), 72'(model_raw(cw)));
            expect_eq("R6 flags", 72'({rd_corrected_o, rd_uncorr_o}), 72'b01);
         end
         expect_eq("R10 corr count", 72'(corr_count_o), 72'(sat(exp_corr)));
         expect_eq("R10 uncorr count", 72'(uncorr_count_o), 72'(sat(exp_unc)));
      end

      // R2 idle cycle after a read
      @(negedge clk);
      expect_eq("R2 idle valid/flags", 72'({rd_valid_o, rd_corrected_o, rd_uncorr_o}), 72'd0);
      expect_eq("R8 no scrub while disabled", 72'(scrub_req_o), 72'd0);

      // R10 saturation of the repaired counter
      for (int j = 0; j < 4; j++) begin
         do_read(8'h40, flip(model_enc(64'(j) * 64'h0101_0101), 7'(10 + j)));
         exp_corr++;
      end
      expect_eq("R10 saturated corr", 72'(corr_count_o), 72'd7);
      expect_eq("R10 uncorr unchanged", 72'(uncorr_count_o), 72'd3);

      // R11 clear alone, then clear together with an uncorrectable read
      cnt_clear_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cnt_clear_i = 1'b0;
      expect_eq("R11 cleared", 72'({corr_count_o, uncorr_count_o}), 72'd0);
      cnt_clear_i = 1'b1;
      do_read(8'h41, flip(flip(model_enc(64'h55), 7'd6), 7'd7));
      cnt_clear_i = 1'b0;
      expect_eq("R11 clear+event uncorr", 72'(uncorr_count_o), 72'd1);
      expect_eq("R11 clear+event corr", 72'(corr_count_o), 72'd0);

      // R8 enabled but uncorrectable
      scrub_en_i = 1'b1;
      do_read(8'h42, flip(flip(model_enc(64'h99), 7'd20), 7'd30));
      expect_eq("R8 no scrub on uncorrectable", 72'(scrub_req_o), 72'd0);

      // R7 request with address and repaired codeword
      xd = 64'h0123_4567_89AB_CDEF;
      do_read(8'h11, flip(model_enc(xd), 7'd10));
      expect_eq("R7 req", 72'(scrub_req_o), 72'd1);
      expect_eq("R7 addr", 72'(scrub_addr_o), 72'h11);
      expect_eq("R7 code", scrub_code_o, model_enc(xd));
      @(negedge clk);
      expect_eq("R7 held req", 72'(scrub_req_o), 72'd1);
      expect_eq("R7 held addr", 72'(scrub_addr_o), 72'h11);

      // R9 a second repaired read while pending does not replace it
      do_read(8'h22, flip(model_enc(64'hFEED), 7'd50));
      expect_eq("R9 kept addr", 72'(scrub_addr_o), 72'h11);
      expect_eq("R9 kept code", scrub_code_o, model_enc(xd));

      // R9 acknowledge in the same cycle as a new repaired read
      scrub_ack_i = 1'b1;
      do_read(8'h33, flip(model_enc(64'hBEEF_0000_CAFE), 7'd0));
      expect_eq("R9 reload req", 72'(scrub_req_o), 72'd1);
      expect_eq("R9 reload addr", 72'(scrub_addr_o), 72'h33);
      expect_eq("R9 reload code", scrub_code_o, model_enc(64'hBEEF_0000_CAFE));
      @(posedge clk);
      @(negedge clk);
      scrub_ack_i = 1'b0;
      expect_eq("R7 released after ack", 72'(scrub_req_o), 72'd0);

      // R8 repaired read with scrubbing disabled
      scrub_en_i = 1'b0;
      do_read(8'h44, flip(model_enc(64'h1), 7'd33));
      expect_eq("R8 disabled flags", 72'(rd_corrected_o), 72'd1);
      expect_eq("R8 disabled no req", 72'(scrub_req_o), 72'd0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule